// File: doc/BRIEF.md
# Flash command sequence interpreter

This block models the command register and control state machine of a parallel NOR flash device. A small word-wide memory array sits behind it. The host drives an address/data bus with active-low chip-enable, write-enable and output-enable. Each clock cycle with chip-enable and write-enable both low is one bus write. Each cycle with chip-enable and output-enable low and write-enable high is one bus read.

Host writes are matched against multi-write unlock sequences, and the matched sequence selects what the read path returns. In the default state, reads return array words. After the identification sequence, reads return fixed codes and per-sector protection bits. While an embedded program or chip erase runs, every read returns a polling word whose bit 7 is the complement of the final value. Program and erase durations are counted in clock cycles and set by parameters. A program merges the new word into the old one with a bitwise AND. A chip erase sweeps the array one word per cycle and writes all ones.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset the block is in array-read mode: `busy` and `dq_valid` are low, and reads return stored words. Every word reads 0xFFFF before any program.
- R2: A read presented in cycle t gives `dq_valid` high and the result on `dq_out` after the second rising edge, and `dq_valid` is low one cycle later when no read follows.
- R3: The unlock pair is data 0xAA to address 0x555 and then data 0x55 to address 0x2AA. In the identification mode (unlock pair, then 0x90 to 0x555), a read with A1:A0 = 00 returns 0x0004 and a read with A1:A0 = 01 returns 0x2257, whatever the other address bits are. Both codes have an odd number of ones.
- R4: In the identification mode, a read with A6 = 0 and A1:A0 = 10 returns bit `PROT_MASK[s]` on DQ0 and zeros elsewhere, where s is the top `SECT_W` address bits. With A6 = 1 the same read returns 0.
- R5: The identification mode is left only by a write of data 0xF0, at any address. Other writes, including a new unlock pair, leave it in place.
- R6: A program is the unlock pair, then 0xA0 to 0x555, then the target address/data write. `busy` rises after the edge of that last write and stays high for exactly `PROG_CYC` cycles.
- R7: After a program, the target word holds the old word AND the written data, and other words are unchanged.
- R8: While `busy` is high, every read returns a word whose bits other than bit 7 are zero. Bit 7 is the complement of bit 7 of the data being programmed, and it is 0 during a chip erase.
- R9: Every write made while `busy` is high is ignored. A full identification sequence written during a program does not take effect.
- R10: A chip erase is the unlock pair, 0x80 to 0x555, the unlock pair again, then 0x10 to 0x555. `busy` stays high for `ERASE_CYC` cycles, after which every word reads 0xFFFF.
- R11: A write that does not match the next expected step of any sequence returns the block to array-read mode. No operation starts, and no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dq_out | output | DATA_W | Registered read result |
| dq_valid | output | 1 | High when dq_out holds a new read result |
| busy | output | 1 | High while an embedded program or erase runs |

## Verification
Forty words spread over the whole array by a stride that is coprime with the depth are programmed with one data pattern. Twelve of them are then programmed again with a second pattern. The first pass separates a plain store from no store, and the second separates AND merging from overwriting. The polling word is read during programs whose data has bit 7 both set and clear, so a flag that is not inverted is caught. The identification codes are read with the upper address bits both zero and set, and every sector is swept with A6 both low and high to tell the protection read apart from the code reads. Sequences broken at each unlock step, and writes made during a busy window, are followed by reads that would expose a started operation. The erase is checked by reading back every word of the array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PSET, S_PBUSY,
    S_ERA1, S_ERA2, S_ERA3, S_EBUSY, S_AUTO
  } seq_st_t;

  typedef enum logic [1:0] {
    RM_ARRAY, RM_ID, RM_STAT
  } rd_mode_t;

  localparam int unsigned CMD_AW = 11;
  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0] KEY_DATA_A = 8'hAA;
  localparam logic [7:0] KEY_DATA_B = 8'h55;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ESETUP  = 8'h80;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_RESET   = 8'hF0;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 2100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  output rd_mode_t          rmode,
  output logic              busy,
  output logic              poll7,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXA  = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH;
  localparam int MAXC  = (MAXA > PROG_CYC) ? MAXA : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] tgt_data;

  logic [CMD_AW-1:0] ca;
  logic [7:0]        cd;
  logic              key_a, key_b, at_key;

  assign ca     = addr[CMD_AW-1:0];
  assign cd     = wdata[7:0];
  assign key_a  = wr && (ca == KEY_ADDR_A) && (cd == KEY_DATA_A);
  assign key_b  = wr && (ca == KEY_ADDR_B) && (cd == KEY_DATA_B);
  assign at_key = wr && (ca == KEY_ADDR_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_READ;
      cnt      <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      unique case (st)
        S_READ: if (key_a) st <= S_UNL1;
        S_UNL1: if (wr) st <= key_b ? S_UNL2 : S_READ;
        S_UNL2: if (wr) begin
          if (at_key && cd == OP_IDENT)       st <= S_AUTO;
          else if (at_key && cd == OP_PROG)   st <= S_PSET;
          else if (at_key && cd == OP_ESETUP) st <= S_ERA1;
          else                                st <= S_READ;
        end
        S_PSET: if (wr) begin
          tgt_addr <= addr;
          tgt_data <= wdata;
          cnt      <= '0;
          st       <= S_PBUSY;
        end
        S_PBUSY: begin
          if (cnt == CNT_W'(PROG_CYC - 1)) st <= S_READ;
          else cnt <= cnt + 1'b1;
        end
        S_ERA1: if (wr) st <= key_a ? S_ERA2 : S_READ;
        S_ERA2: if (wr) st <= key_b ? S_ERA3 : S_READ;
        S_ERA3: if (wr) begin
          if (at_key && cd == OP_CHIP) begin
            cnt <= '0;
            st  <= S_EBUSY;
          end else begin
            st <= S_READ;
          end
        end
        S_EBUSY: begin
          if (cnt == CNT_W'(ERASE_CYC - 1)) st <= S_READ;
          else cnt <= cnt + 1'b1;
        end
        S_AUTO: if (wr && cd == OP_RESET) st <= S_READ;
        default: st <= S_READ;
      endcase
    end
  end

  always_comb begin
    busy      = (st == S_PBUSY) || (st == S_EBUSY);
    poll7     = (st == S_PBUSY) ? ~tgt_data[7] : 1'b0;
    rmode     = busy ? RM_STAT : (st == S_AUTO) ? RM_ID : RM_ARRAY;
    mem_we    = 1'b0;
    mem_waddr = tgt_addr;
    mem_wdata = arr_rdata & tgt_data;
    if (st == S_PBUSY && cnt == CNT_W'(PROG_CYC - 1)) begin
      mem_we = 1'b1;
    end else if (st == S_EBUSY && cnt < CNT_W'(DEPTH)) begin
      mem_we    = 1'b1;
      mem_waddr = cnt[ADDR_W-1:0];
      mem_wdata = '1;
    end
  end
endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          DATA_W    = 16,
  parameter int          SECT_W    = 2,
  parameter logic [31:0] PROT_MASK = 32'h5,
  parameter logic [15:0] MFR_ID    = 16'h0004,
  parameter logic [15:0] DEV_ID    = 16'h2257
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  rd_mode_t          rmode,
  input  logic              poll7,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_valid
);
  logic              v1, a6_1, poll1;
  rd_mode_t          mode1;
  logic [1:0]        lo1;
  logic [SECT_W-1:0] sec1;
  logic [DATA_W-1:0] nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      mode1    <= RM_ARRAY;
      lo1      <= '0;
      a6_1     <= 1'b0;
      sec1     <= '0;
      poll1    <= 1'b0;
      dq_valid <= 1'b0;
      dq_out   <= '0;
    end else begin
      v1       <= rd;
      mode1    <= rmode;
      lo1      <= addr[1:0];
      a6_1     <= addr[6];
      sec1     <= addr[ADDR_W-1 -: SECT_W];
      poll1    <= poll7;
      dq_valid <= v1;
      if (v1) dq_out <= nxt;
    end
  end

  always_comb begin
    nxt = '0;
    unique case (mode1)
      RM_ARRAY: nxt = arr_rdata;
      RM_STAT:  nxt[7] = poll1;
      RM_ID: begin
        if (lo1 == 2'd0)              nxt = DATA_W'(MFR_ID);
        else if (lo1 == 2'd1)         nxt = DATA_W'(DEV_ID);
        else if (lo1 == 2'd2 && !a6_1) nxt[0] = PROT_MASK[sec1];
      end
      default: nxt = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          DATA_W    = 16,
  parameter int          SECT_W    = 2,
  parameter int          PROG_CYC  = 16,
  parameter int          ERASE_CYC = 2100,
  parameter logic [31:0] PROT_MASK = 32'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_valid,
  output logic              busy
);
  logic              wr, rd, poll7, mem_we;
  rd_mode_t          rmode;
  logic [ADDR_W-1:0] tgt_addr, mem_waddr, raddr;
  logic [DATA_W-1:0] mem_wdata, arr_rdata;

  assign wr    = !ce_n && !we_n;
  assign rd    = !ce_n && !oe_n && we_n;
  assign raddr = busy ? tgt_addr : addr;

  flash_cmd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(din),
    .arr_rdata(arr_rdata), .rmode(rmode), .busy(busy), .poll7(poll7),
    .tgt_addr(tgt_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(raddr), .rdata(arr_rdata)
  );

  flash_rd_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .PROT_MASK(PROT_MASK)
  ) u_rd (
    .clk(clk), .rst(rst), .rd(rd), .addr(addr), .rmode(rmode),
    .poll7(poll7), .arr_rdata(arr_rdata), .dq_out(dq_out),
    .dq_valid(dq_valid)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int DATA_W    = 16,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 2100
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_valid,
  input logic              busy
);
  int run;

  always_ff @(posedge clk) begin
    if (rst) run <= 0;
    else if (busy) run <= run + 1;
    else run <= 0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !dq_valid));

  p_read_lag_r2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |-> ##2 dq_valid);

  p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!ce_n && !we_n));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == PROG_CYC || run == ERASE_CYC));

  p_poll_word_r8: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n && busy) |-> ##2
      (dq_out[6:0] == 7'd0 && dq_out[DATA_W-1:8] == '0));
endmodule

bind flash_cmd_top flash_cmd_chk #(
  .DATA_W(DATA_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .dq_out(dq_out), .dq_valid(dq_valid), .busy(busy)
);

// File: tb/tb_flash_cmd_top.sv
module tb_flash_cmd_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;
  localparam int SECT_W = 2;
  localparam int PROG_CYC = 8;
  localparam int ERASE_CYC = 2060;
  localparam logic [31:0] PROT = 32'h6;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0, rst = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dq_out;
  logic dq_valid, busy;

  int n_run = 0, n_fail = 0;
  int run_len = 0, last_len = 0;
  logic [DATA_W-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_top #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_MASK(PROT)
  ) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_valid(dq_valid), .busy(busy)
  );

  always @(negedge clk) begin
    if (busy) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      run_len  = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                          output logic v);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    d = dq_out; v = dq_valid;
  endtask

  task automatic unlock();
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic program_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                              input bit poll, input bit spoil);
    logic [DATA_W-1:0] r;
    logic v;
    unlock();
    bus_write(11'h555, 16'h00A0);
    bus_write(a, d);
    check(busy === 1'b1, "R6 busy after data write", 32'(busy), 1);
    if (spoil) begin
      bus_write(11'h555, 16'h00AA);
      bus_write(11'h2AA, 16'h0055);
      bus_write(11'h555, 16'h0090);
    end
    if (poll) begin
      bus_read(a, r, v);
      check(r === {8'h00, ~d[7], 7'h00}, "R8 program polling word", 32'(r),
            32'({8'h00, ~d[7], 7'h00}));
    end
    wait_idle();
    check(last_len == PROG_CYC, "R6 program busy length", 32'(last_len), PROG_CYC);
    model[a] = model[a] & d;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i, input int k);
    return DATA_W'((i * 947 + k * 31) ^ (k ? 32'h5A3C : 32'hC3A1));
  endfunction

  initial begin
    logic [DATA_W-1:0] r;
    logic v;
    logic [ADDR_W-1:0] a;

    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && dq_valid === 1'b0, "R1 idle after reset",
          32'({busy, dq_valid}), 0);

    bus_read(11'h000, r, v);
    check(r === 16'hFFFF, "R1 array read after reset", 32'(r), 32'hFFFF);
    check(v === 1'b1, "R2 valid two edges after read", 32'(v), 1);
    @(negedge clk);
    check(dq_valid === 1'b0, "R2 valid drops", 32'(dq_valid), 0);

    // R6 R7 R8: first pass over a spread of addresses
    for (int i = 0; i < 40; i++) begin
      a = ADDR_W'((i * 173 + 9) % DEPTH);
      program_word(a, pat(i, 0), (i % 5) == 0, 1'b0);
      bus_read(a, r, v);
      check(r === model[a], "R7 first program", 32'(r), 32'(model[a]));
      bus_read(a + 1'b1, r, v);
      check(r === model[a + 1'b1], "R7 neighbour untouched", 32'(r),
            32'(model[a + 1'b1]));
    end
    // R7: second pass merges by AND
    for (int i = 0; i < 12; i++) begin
      a = ADDR_W'((i * 173 + 9) % DEPTH);
      program_word(a, pat(i, 1), i < 4, 1'b0);
      bus_read(a, r, v);
      check(r === model[a], "R7 AND merge", 32'(r), 32'(model[a]));
    end

    // R9: identification sequence written during a program is ignored
    a = 11'h123;
    program_word(a, 16'h8F0F, 1'b0, 1'b1);
    bus_read(a, r, v);
    check(r === model[a], "R9 writes ignored while busy", 32'(r), 32'(model[a]));
    bus_read(11'h000, r, v);
    check(r === model[0], "R9 still in array mode", 32'(r), 32'(model[0]));

    // R3 identification codes
    unlock();
    bus_write(11'h555, 16'h0090);
    bus_read(11'h000, r, v);
    check(r === 16'h0004, "R3 maker code", 32'(r), 32'h0004);
    bus_read(11'h300, r, v);
    check(r === 16'h0004, "R3 maker code upper bits set", 32'(r), 32'h0004);
    bus_read(11'h001, r, v);
    check(r === 16'h2257, "R3 device code", 32'(r), 32'h2257);
    check($countones(r) % 2 == 1, "R3 odd parity", 32'($countones(r)), 1);
    bus_read(11'h7C1, r, v);
    check(r === 16'h2257, "R3 device code upper bits set", 32'(r), 32'h2257);

    // R4 protection sweep
    for (int s = 0; s < (1 << SECT_W); s++) begin
      a = {2'(s), 9'h002};
      bus_read(a, r, v);
      check(r === {15'd0, PROT[s]}, "R4 sector protect bit", 32'(r), 32'(PROT[s]));
      a = {2'(s), 9'h042};
      bus_read(a, r, v);
      check(r === 16'h0000, "R4 A6 high reads zero", 32'(r), 0);
    end

    // R5 only reset exits
    unlock();
    bus_write(11'h555, 16'h00A0);
    bus_write(11'h010, 16'h0000);
    check(busy === 1'b0, "R5 no program from ident mode", 32'(busy), 0);
    bus_read(11'h000, r, v);
    check(r === 16'h0004, "R5 still ident", 32'(r), 32'h0004);
    bus_write(11'h3FF, 16'h00F0);
    bus_read(11'h000, r, v);
    check(r === model[0], "R5 reset back to array", 32'(r), 32'(model[0]));
    bus_read(11'h010, r, v);
    check(r === model[11'h010], "R5 ignored write left array", 32'(r),
          32'(model[11'h010]));

    // R11 broken sequences
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AB, 16'h0055);
    bus_write(11'h555, 16'h00A0);
    bus_write(11'h020, 16'h0000);
    check(busy === 1'b0, "R11 bad second unlock", 32'(busy), 0);
    unlock();
    bus_write(11'h555, 16'h0077);
    bus_write(11'h020, 16'h0000);
    check(busy === 1'b0, "R11 bad command byte", 32'(busy), 0);
    unlock();
    bus_write(11'h555, 16'h0080);
    unlock();
    bus_write(11'h554, 16'h0010);
    check(busy === 1'b0, "R11 erase at wrong address", 32'(busy), 0);
    bus_read(11'h020, r, v);
    check(r === model[11'h020], "R11 array unchanged", 32'(r), 32'(model[11'h020]));
    bus_read(11'h009, r, v);
    check(r === model[11'h009], "R11 back in array mode", 32'(r), 32'(model[11'h009]));

    // R10 chip erase
    unlock();
    bus_write(11'h555, 16'h0080);
    unlock();
    bus_write(11'h555, 16'h0010);
    check(busy === 1'b1, "R10 erase busy", 32'(busy), 1);
    bus_read(11'h009, r, v);
    check(r === 16'h0000, "R8 erase polling word", 32'(r), 0);
    wait_idle();
    check(last_len == ERASE_CYC, "R10 erase busy length", 32'(last_len), ERASE_CYC);
    begin
      int bad = 0;
      logic [DATA_W-1:0] first_bad = '1;
      for (int i = 0; i < DEPTH; i++) begin
        bus_read(ADDR_W'(i), r, v);
        if (r !== 16'hFFFF && bad == 0) first_bad = r;
        if (r !== 16'hFFFF) bad++;
        model[i] = '1;
      end
      check(bad == 0, "R10 all words erased", 32'(first_bad), 32'hFFFF);
    end
    program_word(11'h009, 16'h1234, 1'b1, 1'b0);
    bus_read(11'h009, r, v);
    check(r === 16'h1234, "R7 program after erase", 32'(r), 32'h1234);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule